// File: doc/BRIEF.md
# I2C Register Target with Split-Write Support

This block is an I2C target that gives a controller access to an external register file through an 8-bit register pointer. It oversamples SCL and SDA with the system clock. It pulls either line low through an open-drain enable. The register file sits behind a plain parallel port: an address bus, a write-data bus, a one-clock write strobe, a one-clock read strobe, and a read-data input that must be valid while the read strobe is high.

Each transfer moves one register. The controller first sends the target's device address with the write direction, then the pointer byte. The data byte may follow at once, which is a plain write. It may also follow a repeated START and a second write-addressed device byte, which is a split write. If the second device byte asks for a read instead, the target returns one byte from the stored pointer. The upper four device-address bits are a parameter. The lower three live in an internal address register that the controller can rewrite through a reserved pointer value. After the pointer byte the target holds SCL low for a fixed number of clocks, which gives the register file time to get ready.

Top module: `i2c_regslave`

## Requirements
- R1: The target acknowledges a device byte whose upper seven bits equal {DEV_HI, current low address}; bit 0 of that byte is R/W, with 1 meaning read. A device byte that does not match is not acknowledged. The target then leaves both lines released and issues no strobe until the next START.
- R2: A plain write (START, device byte with W, pointer, data, STOP) gets an ACK on all three bytes. reg_we pulses high for exactly one clock after the data ACK, with reg_addr equal to the pointer and reg_wdata equal to the data.
- R3: A split write (START, device W, pointer, repeated START, device W, data) writes the data byte to the pointer stored in the first phase.
- R4: A combined read (START, device W, pointer, repeated START, device R) raises reg_re for one clock with reg_addr equal to the pointer. The target then shifts out the reg_rdata value sampled in that clock, MSB first.
- R5: After the one read byte, the target samples the controller's ACK or NACK. In either case it releases SDA and returns no further byte or read strobe.
- R6: A read-addressed device byte that arrives without a pointer stored in the same transfer is not acknowledged.
- R7: After the ACK of the pointer byte, scl_oe is held high for STRETCH_CYC clocks. It begins within three clocks of the SCL falling edge that ends that ACK. scl_oe is never high at any other time.
- R8: Pointer value SA_PTR (default 8'hFF) selects the internal address register. Its reset value is LO_RST. A write there loads data bits [2:0] into it and does not pulse reg_we. The new value applies from the next device byte. A read there returns {5'b0, low address} without pulsing reg_re.
- R9: A STOP in the middle of a byte discards the partial byte and the stored pointer. A START in the middle of a byte discards the partial byte but keeps the pointer, and address matching starts again.
- R10: The target changes SDA only while SCL is low. START and STOP are detected from SDA edges while the synchronized SCL is high.
- R11: Out of reset, sda_oe, scl_oe, reg_we and reg_re are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low (ACK or read bit 0) |
| reg_addr | output | 8 | Register pointer to the register file |
| reg_wdata | output | 8 | Write data to the register file |
| reg_we | output | 1 | One-clock write strobe |
| reg_re | output | 1 | One-clock read strobe |
| reg_rdata | input | 8 | Read data, valid while reg_re is high |

## Verification
The bench drives the bus with a bit-level controller model that honours clock stretching. It aims at the ways a repeated START can change the meaning of the next byte. A design that dropped the pointer on a repeated START would write or read the wrong register. A design that kept it across a STOP would acknowledge a read that has no pointer. Aborted bytes are cut off after three bits by a START and by a STOP, which exposes a shifter that keeps stale bits. Rewriting the internal address register and then addressing both the old and the new address catches a design that strobes the external port instead, or that matches on a stale address.

// File: rtl/i2c_regslave.sv
module i2c_regslave #(
  parameter logic [3:0] DEV_HI      = 4'b1010,
  parameter logic [2:0] LO_RST      = 3'b011,
  parameter logic [7:0] SA_PTR      = 8'hFF,
  parameter int         STRETCH_CYC = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  output logic       reg_re,
  input  logic [7:0] reg_rdata
);

  localparam int SW = $clog2(STRETCH_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_REG, S_WDAT, S_ACK, S_RDAT, S_RACK} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  st_t        st, nxt;
  logic [2:0] cnt, dev_lo;
  logic [7:0] sh, txd, ptr;
  logic       ack_ph, have_ptr, we_pend, str_pend;
  logic [SW-1:0] st_cnt;

  wire scl_s   = scl_sy[1];
  wire sda_s   = sda_sy[1];
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start_c = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c  = scl_s & scl_d & ~sda_d & sda_s;
  wire [7:0] byte_in = {sh[6:0], sda_s};
  wire dev_hit = byte_in[7:1] == {DEV_HI, dev_lo};

  assign scl_oe    = st_cnt != '0;
  assign reg_addr  = ptr;
  assign reg_wdata = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i}; sda_sy <= {sda_sy[0], sda_i};
      scl_d <= scl_s; sda_d <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; nxt <= S_IDLE; cnt <= '0; sh <= '0; txd <= '0; ptr <= '0;
      ack_ph <= 1'b0; have_ptr <= 1'b0; we_pend <= 1'b0; str_pend <= 1'b0;
      dev_lo <= LO_RST; st_cnt <= '0; sda_oe <= 1'b0; reg_we <= 1'b0; reg_re <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      reg_re <= 1'b0;
      if (reg_re) txd <= reg_rdata;
      if (st_cnt != '0) st_cnt <= st_cnt - SW'(1);
      if (start_c) begin
        st <= S_DEV; cnt <= '0; sda_oe <= 1'b0; we_pend <= 1'b0; str_pend <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; have_ptr <= 1'b0; sda_oe <= 1'b0; we_pend <= 1'b0; str_pend <= 1'b0;
      end else begin
        case (st)
          S_DEV, S_REG, S_WDAT: if (scl_rise) begin
            sh  <= byte_in;
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              ack_ph <= 1'b0;
              st     <= S_ACK;
              case (st)
                S_DEV: begin
                  if (!dev_hit || (byte_in[0] && !have_ptr)) st <= S_IDLE;
                  else if (byte_in[0]) begin
                    nxt <= S_RDAT;
                    if (ptr == SA_PTR) txd <= {5'b0, dev_lo};
                    else reg_re <= 1'b1;
                  end else nxt <= have_ptr ? S_WDAT : S_REG;
                end
                S_REG: begin
                  ptr <= byte_in; have_ptr <= 1'b1; str_pend <= 1'b1; nxt <= S_WDAT;
                end
                default: begin
                  we_pend <= 1'b1; nxt <= S_IDLE;
                end
              endcase
            end
          end
          S_ACK: if (scl_fall) begin
            if (!ack_ph) begin
              ack_ph <= 1'b1;
              sda_oe <= 1'b1;
            end else begin
              st  <= nxt;
              cnt <= '0;
              sda_oe <= (nxt == S_RDAT) ? ~txd[7] : 1'b0;
              if (str_pend) st_cnt <= SW'(STRETCH_CYC);
              str_pend <= 1'b0;
              if (we_pend) begin
                have_ptr <= 1'b0;
                if (ptr == SA_PTR) dev_lo <= sh[2:0];
                else reg_we <= 1'b1;
              end
              we_pend <= 1'b0;
            end
          end
          S_RDAT: if (scl_fall) begin
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              sda_oe <= 1'b0;
              st <= S_RACK;
            end else begin
              txd <= {txd[6:0], 1'b0};
              sda_oe <= ~txd[6];
            end
          end
          S_RACK: if (scl_rise) begin
            st <= S_IDLE;
            have_ptr <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  p_we_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  p_we_after_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(st == S_ACK));
  p_re_for_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |-> (st == S_ACK && nxt == S_RDAT));
  p_stretch_only_wdat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> st == S_WDAT);
  p_sda_on_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);

endmodule

// File: tb/i2c_regslave_tb.sv
module i2c_regslave_tb;
  localparam int H = 12;
  localparam int STR = 40;
  localparam logic [3:0] HI = 4'b1010;
  localparam logic [7:0] SA = 8'hFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_oe, sda_oe, reg_we, reg_re;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  wire scl = !(m_scl_low | scl_oe);
  wire sda = !(m_sda_low | sda_oe);

  logic [7:0] env_mem [256];
  logic [7:0] exp_mem [256];
  int n_chk = 0, n_bad = 0, we_cnt = 0, re_cnt = 0;
  int last_wait, first_wait, r10_bad;
  logic [7:0] we_addr, we_data;
  logic [2:0] lo = 3'b011;

  always #4 clk = ~clk;
  assign reg_rdata = env_mem[reg_addr];

  i2c_regslave #(.DEV_HI(HI), .LO_RST(3'b011), .SA_PTR(SA), .STRETCH_CYC(STR)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
    .reg_rdata(reg_rdata));

  always @(posedge clk) begin
    if (reg_we) begin
      env_mem[reg_addr] <= reg_wdata;
      we_cnt <= we_cnt + 1; we_addr <= reg_addr; we_data <= reg_wdata;
    end
    if (reg_re) re_cnt <= re_cnt + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_high();
    int w = 0;
    while (!scl && w < 1000) begin tick(1); w++; end
    last_wait = w;
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; tick(H);
    m_scl_low = 1'b0; wait_high(); tick(H);
    m_sda_low = 1'b1; tick(H);
    m_scl_low = 1'b1; tick(2);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; tick(H);
    m_scl_low = 1'b0; wait_high(); tick(H);
    m_sda_low = 1'b0; tick(H);
  endtask

  task automatic send_bit(input bit b);
    m_sda_low = !b; tick(H);
    m_scl_low = 1'b0; wait_high(); tick(H);
    m_scl_low = 1'b1; tick(2);
  endtask

  task automatic recv_bit(output bit b);
    bit b1;
    m_sda_low = 1'b0; tick(H);
    m_scl_low = 1'b0; wait_high(); tick(H / 2);
    b1 = sda; tick(H / 2);
    b = sda;
    if (b1 != b) r10_bad++;
    m_scl_low = 1'b1; tick(2);
  endtask

  task automatic send_byte(input logic [7:0] d, output bit ack);
    bit a;
    for (int i = 7; i >= 0; i--) begin
      send_bit(d[i]);
      if (i == 7) first_wait = last_wait;
    end
    recv_bit(a);
    ack = !a;
  endtask

  task automatic recv_byte(output logic [7:0] d, input bit m_ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
    send_bit(!m_ack);
  endtask

  function automatic logic [7:0] dev(input logic [2:0] l, input bit rd);
    return {HI, l, rd};
  endfunction

  task automatic do_write(input logic [7:0] p, input logic [7:0] d, input bit split, input string req);
    bit a0, a1, a2, a3;
    int w0 = we_cnt;
    a3 = 1'b1;
    bus_start(); send_byte(dev(lo, 0), a0); send_byte(p, a1);
    if (split) begin bus_start(); send_byte(dev(lo, 0), a3); end
    send_byte(d, a2);
    if (!split) check({req, " R7 stretch"}, int'(first_wait >= STR - H && first_wait <= STR), 1);
    bus_stop();
    check({req, " acks"}, {a0, a1, a2, a3}, 4'hF);
    check({req, " we count"}, we_cnt - w0, 1);
    check({req, " addr"}, we_addr, p);
    check({req, " data"}, we_data, d);
    exp_mem[p] = d;
  endtask

  task automatic do_read(input logic [7:0] p, input bit m_ack, input string req, output logic [7:0] d);
    bit a0, a1, a2;
    int r0 = re_cnt;
    bus_start(); send_byte(dev(lo, 0), a0); send_byte(p, a1);
    bus_start(); send_byte(dev(lo, 1), a2);
    r10_bad = 0;
    recv_byte(d, m_ack);
    check("R10 sda stable while scl high", r10_bad, 0);
    check("R5 sda released after read", sda_oe, 0);
    bus_stop();
    check({req, " acks"}, {a0, a1, a2}, 3'h7);
    check({req, " R5 one read strobe"}, re_cnt - r0, 1);
  endtask

  initial begin
    logic [7:0] d;
    bit a, b;
    int w0;
    void'($urandom(32'd2718));
    for (int i = 0; i < 256; i++) begin
      env_mem[i] = 8'(i * 7 + 3); exp_mem[i] = 8'(i * 7 + 3);
    end
    tick(5);
    check("R11 sda_oe at reset", sda_oe, 0);
    check("R11 scl_oe at reset", scl_oe, 0);
    check("R11 strobes at reset", {reg_we, reg_re}, 0);
    rst_n = 1'b1; tick(5);

    do_write(8'h10, 8'hA5, 1'b0, "R2 plain write");
    do_write(8'h22, 8'h3C, 1'b1, "R3 split write");
    do_read(8'h10, 1'b0, "R4 read nack", d);
    check("R4 read data", d, 8'hA5);
    do_read(8'h22, 1'b1, "R5 read ack", d);
    check("R3 split data readback", d, 8'h3C);

    w0 = we_cnt;
    bus_start(); send_byte(dev(3'b000, 0), a);
    check("R1 mismatch not acked", a, 0);
    send_byte(8'h10, a); check("R1 ignored pointer", a, 0);
    send_byte(8'h77, a); check("R1 ignored data", a, 0);
    bus_stop();
    check("R1 no write on mismatch", we_cnt - w0, 0);

    bus_start(); send_byte(dev(lo, 1), a); bus_stop();
    check("R6 read without pointer", a, 0);

    bus_start(); send_byte(dev(lo, 0), a); send_byte(8'h10, b);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    bus_stop();
    bus_start(); send_byte(dev(lo, 1), a); bus_stop();
    check("R9 stop drops pointer", a, 0);

    w0 = we_cnt;
    bus_start(); send_byte(dev(lo, 0), a); send_byte(8'h22, b);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    bus_start(); send_byte(dev(lo, 1), a);
    check("R9 start keeps pointer ack", a, 1);
    recv_byte(d, 1'b0); bus_stop();
    check("R9 start keeps pointer data", d, exp_mem[8'h22]);
    check("R9 partial byte not written", we_cnt - w0, 0);

    w0 = we_cnt;
    bus_start(); send_byte(dev(lo, 0), a); send_byte(SA, a); send_byte(8'hF5, a); bus_stop();
    check("R8 no port write", we_cnt - w0, 0);
    bus_start(); send_byte(dev(3'b011, 0), a); bus_stop();
    check("R8 old address refused", a, 0);
    lo = 3'b101;
    w0 = re_cnt;
    bus_start(); send_byte(dev(lo, 0), a); send_byte(SA, b);
    check("R8 new address accepted", a, 1);
    bus_start(); send_byte(dev(lo, 1), a); recv_byte(d, 1'b0); bus_stop();
    check("R8 readback", d, 8'h05);
    check("R8 no read strobe", re_cnt - w0, 0);

    for (int k = 0; k < 36; k++) begin
      logic [7:0] p, v;
      p = 8'($urandom % 255);
      v = 8'($urandom);
      case ($urandom % 3)
        0: do_write(p, v, 1'b0, "R2 random");
        1: do_write(p, v, 1'b1, "R3 random");
        default: begin
          do_read(p, 1'($urandom % 2), "R4 random", d);
          check("R4 random data", d, exp_mem[p]);
        end
      endcase
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule